// File: doc/BRIEF.md
# Maskable Prioritized Interrupt Controller

This block collects interrupt requests from twelve external pins and twenty-one internal peripheral lines, holds each one in a pending flag, and presents the most urgent eligible request to the CPU as a request bit and a vector number. Each external pin is first synchronised. It then sets its flag on either a rising or a falling transition, and the edge is chosen per pin. Internal lines set their flag on any cycle in which they are high.

The CPU side has four controls. A global mask bit stops interrupts from being accepted, but flags still latch while it is set. A per-source clear strobe removes a flag. An accept strobe sets the global mask again. A lockout holds every request back from reset until the CPU reports that its first instruction has completed, so the first instruction always runs before any interrupt can be taken. Source order is external group one (indices 0–3), then external group two (4–11), then internal lines (12–32). Index 0 is the most urgent, and the vector number equals the index.

Top module: `irq_ctrl_top`

## Requirements
- R1: During and right after reset, irq_req is 0 and irq_vec is 0, the global mask is 1 and the lockout is active.
- R2: With ext_rise[j]=1, a 0→1 change on ext_pin[j] sets flag j, and with ext_rise[j]=0 a 1→0 change sets it. The opposite transition sets nothing. The request appears on the third rising clock edge after the pin changes.
- R3: int_req[i] high at a clock edge sets flag 12+i, and the request is visible from that same edge.
- R4: A flag stays set until its clr_flag bit is pulsed. If a set and a clear for the same flag coincide, the flag stays set.
- R5: While the global mask is 1, flags still latch but irq_req stays 0. After the mask is written to 0, the pending request appears at the next edge.
- R6: Among eligible pending flags, irq_vec carries the lowest index, and irq_req is 1.
- R7: A flag whose src_en bit is 0 is not eligible but stays latched. Re-enabling it makes it eligible again.
- R8: irq_req stays 0 from reset until first_done has been pulsed once.
- R9: irq_ack while irq_req is 1 sets the global mask, so irq_req is 0 from that edge on. Pending flags are kept.
- R10: mask_wr loads mask_val into the global mask. If irq_ack is accepted in the same cycle, the mask becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 12 | Asynchronous external request pins |
| ext_rise | input | 12 | Per-pin edge select: 1 rising, 0 falling |
| int_req | input | 21 | Internal peripheral request lines |
| src_en | input | 33 | Per-source enable |
| clr_flag | input | 33 | Per-source flag clear strobes |
| mask_wr | input | 1 | Global mask write strobe |
| mask_val | input | 1 | Value for the global mask write |
| irq_ack | input | 1 | CPU accepts the presented request |
| first_done | input | 1 | CPU finished its first instruction after reset |
| irq_req | output | 1 | Registered request to the CPU |
| irq_vec | output | 6 | Registered vector number (source index) |

## Verification
A wrong flag, mask or lockout state shows up as a missing or extra irq_req, or as a wrong irq_vec, at the next clock edge, because both outputs are registered from next-state values. A fault in the synchroniser or the edge select shifts the request edge away from the third edge after the pin change, or makes the request follow the wrong transition. The bench fixes each cycle count exactly, so these faults are caught in the cycle where they occur. Priority faults are exposed by clearing a full set of 33 flags one at a time and following irq_vec through every index.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned EXT_GRP_A = 4;
  localparam int unsigned EXT_GRP_B = 8;
  localparam int unsigned INT_SRCS  = 21;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_sel_e;

  function automatic int unsigned vec_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_hit
);
  import irq_ctrl_pkg::*;

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  always_comb begin
    if (edge_sel_e'(rise_sel) == EDGE_RISE)
      edge_hit = sync_q[STAGES-1] & ~last_q;
    else
      edge_hit = ~sync_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 33
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_d
);
  logic [N-1:0] flags_q;

  // set beats clear when both strike the same flag
  always_comb flags_d = (flags_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 33,
  parameter int unsigned W = 6
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int unsigned N_EXT_A = irq_ctrl_pkg::EXT_GRP_A,
  parameter int unsigned N_EXT_B = irq_ctrl_pkg::EXT_GRP_B,
  parameter int unsigned N_INT   = irq_ctrl_pkg::INT_SRCS,
  parameter int unsigned N_EXT   = N_EXT_A + N_EXT_B,
  parameter int unsigned N_SRC   = N_EXT + N_INT,
  parameter int unsigned VEC_W   = irq_ctrl_pkg::vec_bits(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_EXT-1:0] ext_rise,
  input  logic [N_INT-1:0] int_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] clr_flag,
  input  logic             mask_wr,
  input  logic             mask_val,
  input  logic             irq_ack,
  input  logic             first_done,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  import irq_ctrl_pkg::*;

  logic [N_EXT-1:0] ext_hit;
  logic [N_SRC-1:0] set_all;
  logic [N_SRC-1:0] flags_d;
  logic [N_SRC-1:0] elig_d;
  logic             any_d;
  logic [VEC_W-1:0] win_d;
  logic             mask_q, mask_d;
  logic             lock_q, lock_d;
  logic             req_d;

  for (genvar j = 0; j < N_EXT; j++) begin : g_ext
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .pin      (ext_pin[j]),
      .rise_sel (ext_rise[j]),
      .edge_hit (ext_hit[j])
    );
  end

  assign set_all = {int_req, ext_hit};

  irq_flag_bank #(.N(N_SRC)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_all),
    .clr_i   (clr_flag),
    .flags_d (flags_d)
  );

  assign elig_d = flags_d & src_en;

  irq_prio_pick #(.N(N_SRC), .W(VEC_W)) u_pick (
    .req (elig_d),
    .any (any_d),
    .idx (win_d)
  );

  always_comb begin
    if (irq_ack && irq_req) mask_d = 1'b1;
    else if (mask_wr)       mask_d = mask_val;
    else                    mask_d = mask_q;
    lock_d = lock_q & ~first_done;
    req_d  = any_d & ~mask_d & ~lock_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= 1'b1;
      lock_q  <= 1'b1;
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      mask_q  <= mask_d;
      lock_q  <= lock_d;
      irq_req <= req_d;
      irq_vec <= win_d;
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N_SRC = 33,
  parameter int unsigned VEC_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] src_en,
  input logic             mask_wr,
  input logic             mask_val,
  input logic             irq_ack,
  input logic             first_done,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec
);
  logic             seen_done_q;
  logic [N_SRC-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_done_q <= 1'b0;
      en_q        <= '0;
    end else begin
      if (first_done) seen_done_q <= 1'b1;
      en_q <= src_en;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq_req && irq_vec == '0));

  a_r8_lockout: assert property (@(posedge clk) disable iff (rst)
    !seen_done_q |-> !irq_req);

  a_r9_ack_masks: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack) |=> !irq_req);

  a_r10_mask_write: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && mask_val) |=> !irq_req);

  a_r6_vec_range: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (int'(irq_vec) < int'(N_SRC)));

  a_r7_enabled_only: assert property (@(posedge clk) disable iff (rst)
    (irq_req && int'(irq_vec) < int'(N_SRC)) |-> en_q[irq_vec]);
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_en     (src_en),
  .mask_wr    (mask_wr),
  .mask_val   (mask_val),
  .irq_ack    (irq_ack),
  .first_done (first_done),
  .irq_req    (irq_req),
  .irq_vec    (irq_vec)
);

// File: tb/irq_ctrl_top_tb.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb;
  localparam int NE = 12;
  localparam int NI = 21;
  localparam int NS = 33;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] ext_pin = '0;
  logic [NE-1:0] ext_rise = '1;
  logic [NI-1:0] int_req = '0;
  logic [NS-1:0] src_en = '1;
  logic [NS-1:0] clr_flag = '0;
  logic          mask_wr = 1'b0;
  logic          mask_val = 1'b0;
  logic          irq_ack = 1'b0;
  logic          first_done = 1'b0;
  logic          irq_req;
  logic [5:0]    irq_vec;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl_top u_dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_rise(ext_rise),
    .int_req(int_req), .src_en(src_en), .clr_flag(clr_flag),
    .mask_wr(mask_wr), .mask_val(mask_val), .irq_ack(irq_ack),
    .first_done(first_done), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_src(input int s);
    clr_flag[s] = 1'b1;
    tick();
    clr_flag[s] = 1'b0;
  endtask

  task automatic pulse_int(input int i);
    int_req[i] = 1'b1;
    tick();
    int_req[i] = 1'b0;
  endtask

  task automatic write_mask(input logic v);
    mask_wr = 1'b1; mask_val = v;
    tick();
    mask_wr = 1'b0;
  endtask

  initial begin
    tick(3);
    // R1: reset state
    check("R1 req", int'(irq_req), 0);
    check("R1 vec", int'(irq_vec), 0);
    rst = 1'b0;
    tick();
    check("R1 req after release", int'(irq_req), 0);

    // R5/R8: unmask but lockout still active
    write_mask(1'b0);
    pulse_int(20);
    check("R8 locked", int'(irq_req), 0);
    tick(3);
    check("R8 still locked", int'(irq_req), 0);
    first_done = 1'b1;
    tick();
    first_done = 1'b0;
    check("R8 released req", int'(irq_req), 1);
    check("R8 released vec", int'(irq_vec), 32);

    // R4: flag persists, clear removes it
    tick(5);
    check("R4 persists", int'(irq_req), 1);
    clear_src(32);
    check("R4 cleared", int'(irq_req), 0);

    // R2: per-pin edge select, both polarities
    for (int j = 0; j < NE; j++) begin
      ext_rise[j] = 1'b1;
      ext_pin[j] = 1'b1;
      tick(2);
      check("R2 rise latency", int'(irq_req), 0);
      tick();
      check("R2 rise req", int'(irq_req), 1);
      check("R2 rise vec", int'(irq_vec), j);
      clear_src(j);
      check("R2 rise clr", int'(irq_req), 0);
      ext_pin[j] = 1'b0;
      tick(4);
      check("R2 fall ignored", int'(irq_req), 0);
      ext_rise[j] = 1'b0;
      ext_pin[j] = 1'b1;
      tick(4);
      check("R2 rise ignored", int'(irq_req), 0);
      ext_pin[j] = 1'b0;
      tick(2);
      check("R2 fall latency", int'(irq_req), 0);
      tick();
      check("R2 fall req", int'(irq_req), 1);
      check("R2 fall vec", int'(irq_vec), j);
      clear_src(j);
      ext_rise[j] = 1'b1;
      tick();
      check("R2 fall clr", int'(irq_req), 0);
    end

    // R3: each internal line
    for (int i = 0; i < NI; i++) begin
      pulse_int(i);
      check("R3 req", int'(irq_req), 1);
      check("R3 vec", int'(irq_vec), 12 + i);
      clear_src(12 + i);
      check("R3 clr", int'(irq_req), 0);
    end

    // R6: all sources pending, clear ascending
    ext_pin = '1;
    int_req = '1;
    tick();
    int_req = '0;
    tick(2);
    for (int s = 0; s < NS; s++) begin
      check("R6 req", int'(irq_req), 1);
      check("R6 vec", int'(irq_vec), s);
      clear_src(s);
    end
    check("R6 none left", int'(irq_req), 0);
    ext_pin = '0;
    tick(4);
    check("R6 fall ignored", int'(irq_req), 0);

    // R7: enable gating keeps flags
    int_req[0] = 1'b1; int_req[1] = 1'b1;
    tick();
    int_req = '0;
    check("R7 both vec", int'(irq_vec), 12);
    src_en[12] = 1'b0;
    tick();
    check("R7 skip vec", int'(irq_vec), 13);
    src_en[13] = 1'b0;
    tick();
    check("R7 none eligible", int'(irq_req), 0);
    src_en[12] = 1'b1;
    tick();
    check("R7 kept req", int'(irq_req), 1);
    check("R7 kept vec", int'(irq_vec), 12);
    src_en[13] = 1'b1;
    clear_src(12);
    clear_src(13);
    check("R7 cleared", int'(irq_req), 0);

    // R4: set wins over clear in the same cycle
    int_req[3] = 1'b1; clr_flag[15] = 1'b1;
    tick();
    int_req[3] = 1'b0; clr_flag[15] = 1'b0;
    check("R4 set wins req", int'(irq_req), 1);
    check("R4 set wins vec", int'(irq_vec), 15);

    // R9: ack sets mask, flag kept
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    check("R9 ack drops req", int'(irq_req), 0);
    tick(3);
    check("R9 stays masked", int'(irq_req), 0);
    // R5: flags latch while masked
    pulse_int(2);
    check("R5 masked", int'(irq_req), 0);
    write_mask(1'b0);
    check("R5 unmask req", int'(irq_req), 1);
    check("R5 unmask vec", int'(irq_vec), 14);
    clear_src(14);
    check("R9 kept vec", int'(irq_vec), 15);

    // R10: ack beats a same-cycle unmask write
    irq_ack = 1'b1; mask_wr = 1'b1; mask_val = 1'b0;
    tick();
    irq_ack = 1'b0; mask_wr = 1'b0;
    check("R10 ack wins", int'(irq_req), 0);
    write_mask(1'b0);
    check("R10 write 0", int'(irq_req), 1);
    write_mask(1'b1);
    check("R10 write 1", int'(irq_req), 0);
    clear_src(15);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule